// File: doc/BRIEF.md
# Dual-Path Host I/O Port Interface

This block sits on the device side of a byte-wide host I/O bus. It offers the host two ways to reach one device. The slow link is a set of four byte registers: a reply byte the host reads, a byte the host writes, and one status register for each of those two directions. The fast path is a word port. The host writes each 16-bit word as a low byte and then a high byte at two adjacent addresses. A separate status register reports whether the host may use the fast path, and a control input from the device's protocol engine drives that register.

A fast burst opens only after the host writes the tag byte 0x40 to the slow output-data register while the fast path is enabled. The block turns every accepted host write into one entry of a single outbound stream. Each entry is a plain byte, a tag marker or a reassembled word, and the stream feeds the device's message parser. Replies from the device always go back through the slow link, even while bursts are in use. The block decodes the addresses, pairs the word halves, tracks the burst state, flags malformed word writes and buffers bytes in both directions.

Top module: `hostio_dual_port`

## Requirements
- R1: Read decode, with registered read data one cycle after the read strobe. BASE+2 (0x152) returns bit 0 = 1 when a reply byte is waiting. BASE+3 (0x153) returns bit 0 = 1 when the outbound stream can take another entry. 0x160 returns bit 0 = the fast-path enable. All upper bits are 0, and every unmapped address reads 0x00.
- R2: A read of BASE+0 (0x150) returns the oldest buffered reply byte and removes it. With no reply waiting it returns 0x00 and removes nothing. rp_ready is low while the reply buffer (depth 4) is full, and a byte offered then is lost.
- R3: A write to BASE+1 (0x151) that is not a tag pushes a stream entry with kind 0 (byte) and data {8'h00, byte}. When the fast path is disabled, this holds for every value, including 0x40.
- R4: A write of 0x40 to BASE+1 while the fast path is enabled pushes kind 1 (tag) with data 0x0040 and opens a burst.
- R5: In an open burst, a write to BASE+4 (0x154) holds a low byte. A write to BASE+5 (0x155) then pushes kind 2 (word) with data {high, low}. A second low write before the high one replaces the first.
- R6: A high-byte write in an open burst with no held low byte raises err for one cycle and pushes nothing.
- R7: A write to either word address when no burst is open raises err for one cycle and pushes nothing.
- R8: A non-tag write to BASE+1, or disabling the fast path, closes the burst and discards any held low byte.
- R9: While the outbound stream (depth 4) is full, output-status bit 0 reads 0, and writes to BASE+1 and completed words are lost.
- R10: Reset empties both buffers, closes any burst and clears the fast-path status. The enable status follows the fifo_en input one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe, one cycle per read |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Registered host read byte |
| fifo_en | input | 1 | Fast-path permission from the protocol engine |
| rp_valid | input | 1 | Device offers a reply byte |
| rp_data | input | 8 | Reply byte |
| rp_ready | output | 1 | Reply buffer can take a byte |
| st_valid | output | 1 | Outbound stream entry available |
| st_kind | output | 2 | Entry kind: 0 byte, 1 tag, 2 word |
| st_data | output | 16 | Entry data |
| st_ready | input | 1 | Parser takes the current entry |
| err | output | 1 | One-cycle pulse for a rejected word-port write |

## Verification
The hardest case to reach from the ports is an open burst that meets a full outbound buffer. In that case a word that completes correctly must still vanish, and the entries that are already queued must stay intact. To reach it, the bench holds st_ready low and sends a tag followed by three words, which fills the four-entry buffer. It reads the output status, sends one more word pair, and then drains the buffer and compares the entries. Orphan high bytes, repeated low bytes and word writes outside a burst are placed around bursts that are opened and closed on purpose, and the bench counts the err pulses that follow.

// File: rtl/hostio_pkg.sv
package hostio_pkg;
  typedef enum logic [1:0] {
    K_BYTE = 2'd0,
    K_TAG  = 2'd1,
    K_WORD = 2'd2
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [15:0] data;
  } ent_t;

  localparam logic [7:0] TAG_BYTE = 8'h40;
endpackage

// File: rtl/hio_sync_fifo.sv
module hio_sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CAP);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R9 / R2: occupancy never exceeds capacity
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    count <= CAP);
  // R2: an empty buffer stays empty when only popped
  p_empty_pop_r2: assert property (@(posedge clk) disable iff (rst)
    (empty && !push) |=> empty);
endmodule

// File: rtl/hio_word_asm.sv
module hio_word_asm (
  input  logic        clk,
  input  logic        rst,
  input  logic        fen,
  input  logic        tag_wr,
  input  logic        byte_wr,
  input  logic        lo_wr,
  input  logic        hi_wr,
  input  logic [7:0]  wdata,
  output logic        word_push,
  output logic [15:0] word,
  output logic        err
);
  logic       armed_q, lo_vld_q;
  logic [7:0] lo_q;

  always_comb begin
    word_push = hi_wr && armed_q && lo_vld_q;
    word      = {wdata, lo_q};
    err       = ((lo_wr || hi_wr) && !armed_q) ||
                (hi_wr && armed_q && !lo_vld_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      lo_vld_q <= 1'b0;
      lo_q     <= '0;
    end else begin
      if (!fen)         armed_q <= 1'b0;
      else if (tag_wr)  armed_q <= 1'b1;
      else if (byte_wr) armed_q <= 1'b0;

      if (!fen || tag_wr || byte_wr || hi_wr) lo_vld_q <= 1'b0;
      else if (lo_wr && armed_q)              lo_vld_q <= 1'b1;

      if (lo_wr && armed_q) lo_q <= wdata;
    end
  end

  // R8 / R7: a burst can only be open while the fast path was enabled
  p_armed_fen_r7: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> $past(fen));
  // R6: a rejected write never produces a word
  p_err_excl_r6: assert property (@(posedge clk) disable iff (rst)
    err |-> !word_push);
endmodule

// File: rtl/hostio_dual_port.sv
module hostio_dual_port #(
  parameter int ADDR_W     = 10,
  parameter int BASE       = 'h150,
  parameter int FEN_ADDR   = 'h160,
  parameter int RPLY_DEPTH = 4,
  parameter int OUT_DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              fifo_en,
  input  logic              rp_valid,
  input  logic [7:0]        rp_data,
  output logic              rp_ready,
  output logic              st_valid,
  output logic [1:0]        st_kind,
  output logic [15:0]       st_data,
  input  logic              st_ready,
  output logic              err
);
  import hostio_pkg::*;

  localparam logic [ADDR_W-1:0] A_IDATA = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_ODATA = ADDR_W'(BASE + 1);
  localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(BASE + 2);
  localparam logic [ADDR_W-1:0] A_OSTAT = ADDR_W'(BASE + 3);
  localparam logic [ADDR_W-1:0] A_FLO   = ADDR_W'(BASE + 4);
  localparam logic [ADDR_W-1:0] A_FHI   = ADDR_W'(BASE + 5);
  localparam logic [ADDR_W-1:0] A_FEN   = ADDR_W'(FEN_ADDR);
  localparam int EW = $bits(ent_t);

  logic        fen_q;
  logic        rp_full, rp_empty, rp_pop;
  logic [7:0]  rp_head;
  logic        out_full, out_empty, out_push;
  ent_t        out_in, out_head;
  logic        hit_odata, is_tag, tag_wr, byte_wr, lo_wr, hi_wr;
  logic        word_push, asm_err;
  logic [15:0] word;

  always_ff @(posedge clk) begin
    if (rst) fen_q <= 1'b0;
    else     fen_q <= fifo_en;
  end

  // Write decode
  always_comb begin
    hit_odata = io_wr && (io_addr == A_ODATA);
    is_tag    = hit_odata && fen_q && (io_wdata == TAG_BYTE);
    tag_wr    = is_tag && !out_full;
    byte_wr   = hit_odata && !is_tag && !out_full;
    lo_wr     = io_wr && (io_addr == A_FLO);
    hi_wr     = io_wr && (io_addr == A_FHI);
    out_push  = tag_wr || byte_wr || (word_push && !out_full);
    if (tag_wr)       out_in = '{kind: K_TAG,  data: {8'h00, TAG_BYTE}};
    else if (byte_wr) out_in = '{kind: K_BYTE, data: {8'h00, io_wdata}};
    else              out_in = '{kind: K_WORD, data: word};
  end

  hio_word_asm u_asm (
    .clk(clk), .rst(rst), .fen(fen_q),
    .tag_wr(tag_wr), .byte_wr(byte_wr), .lo_wr(lo_wr), .hi_wr(hi_wr),
    .wdata(io_wdata), .word_push(word_push), .word(word), .err(asm_err)
  );

  hio_sync_fifo #(.W(EW), .DEPTH(OUT_DEPTH)) u_out (
    .clk(clk), .rst(rst),
    .push(out_push), .din(out_in), .full(out_full),
    .pop(st_ready), .dout(out_head), .empty(out_empty)
  );

  hio_sync_fifo #(.W(8), .DEPTH(RPLY_DEPTH)) u_rply (
    .clk(clk), .rst(rst),
    .push(rp_valid), .din(rp_data), .full(rp_full),
    .pop(rp_pop), .dout(rp_head), .empty(rp_empty)
  );

  assign rp_ready = !rp_full;
  assign rp_pop   = io_rd && (io_addr == A_IDATA) && !rp_empty;
  assign st_valid = !out_empty;
  assign st_kind  = out_head.kind;
  assign st_data  = out_head.data;

  // Registered read data and error pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
      err      <= 1'b0;
    end else begin
      err <= asm_err;
      if (io_rd) begin
        if (io_addr == A_IDATA)      io_rdata <= rp_empty ? 8'h00 : rp_head;
        else if (io_addr == A_ISTAT) io_rdata <= {7'b0, !rp_empty};
        else if (io_addr == A_OSTAT) io_rdata <= {7'b0, !out_full};
        else if (io_addr == A_FEN)   io_rdata <= {7'b0, fen_q};
        else                         io_rdata <= 8'h00;
      end
    end
  end

  // R1: enable status reads back what the engine set
  p_fen_read_r1: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == A_FEN) |=> io_rdata == {7'b0, $past(fen_q)});
  // R4: a tag entry only enters the stream with the fast path enabled
  p_tag_fen_r4: assert property (@(posedge clk) disable iff (rst)
    (!out_empty && out_head.kind == K_TAG && $rose(st_valid)) |-> $past(fen_q));
endmodule

// File: tb/hostio_dual_port_bench.sv
module hostio_dual_port_bench;
  logic        clk = 0, rst = 1;
  logic [9:0]  io_addr = '0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic        fifo_en = 0, rp_valid = 0, rp_ready;
  logic [7:0]  rp_data = '0;
  logic        st_valid, st_ready = 0, err;
  logic [1:0]  st_kind;
  logic [15:0] st_data;

  int checks = 0, errors = 0, err_cnt = 0;
  logic done = 0;

  always #5 clk = ~clk;

  hostio_dual_port u_hostio_dual_port (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .fifo_en(fifo_en),
    .rp_valid(rp_valid), .rp_data(rp_data), .rp_ready(rp_ready),
    .st_valid(st_valid), .st_kind(st_kind), .st_data(st_data),
    .st_ready(st_ready), .err(err)
  );

  always @(posedge clk) if (!rst && err) err_cnt++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(int a, int d);
    @(negedge clk); io_addr = 10'(a); io_wdata = 8'(d); io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic host_rd(int a, output int v);
    @(negedge clk); io_addr = 10'(a); io_rd = 1;
    @(negedge clk); io_rd = 0; v = io_rdata;
  endtask

  task automatic rp_push(int d);
    @(negedge clk); rp_data = 8'(d); rp_valid = 1;
    @(negedge clk); rp_valid = 0;
  endtask

  // pops one entry; checks kind and data
  task automatic expect_entry(string req, int k, int d);
    @(negedge clk);
    check(req, st_valid, 1);
    check(req, st_kind, k);
    check(req, st_data, d);
    st_ready = 1;
    @(negedge clk); st_ready = 0;
  endtask

  task automatic expect_empty(string req);
    @(negedge clk); check(req, st_valid, 0);
  endtask

  initial begin
    int v, e0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    host_rd('h152, v); check("R10 istat", v, 0);
    host_rd('h153, v); check("R10 ostat", v, 1);
    host_rd('h160, v); check("R10 fen", v, 0);
    expect_empty("R10 stream");
    // R1 unmapped sweep
    for (int a = 'h140; a < 'h180; a++) begin
      if (a < 'h150 || a > 'h153) if (a != 'h160) begin
        host_rd(a, v); check("R1 unmapped", v, 0);
      end
    end
    // R2 empty reply read
    host_rd('h150, v); check("R2 empty read", v, 0);
    // R2 replies, two rounds plus overflow
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 4; i++) rp_push((i * 'h55 + 3 + r * 7) & 'hff);
      @(negedge clk); check("R2 rp_ready full", rp_ready, 0);
      rp_push('hEE);
      host_rd('h152, v); check("R1 istat set", v, 1);
      for (int i = 0; i < 4; i++) begin
        host_rd('h150, v); check("R2 reply order", v, (i * 'h55 + 3 + r * 7) & 'hff);
      end
      host_rd('h152, v); check("R1 istat clear", v, 0);
    end
    // R3 every byte value with fast path off
    for (int b = 0; b < 256; b++) begin
      host_wr('h151, b);
      expect_entry("R3 byte", 0, b);
    end
    // R7 word write while disabled
    e0 = err_cnt;
    host_wr('h154, 'h11); host_wr('h155, 'h22); @(negedge clk);
    check("R7 err disabled", err_cnt - e0, 2);
    expect_empty("R7 nothing pushed");
    // enable
    fifo_en = 1; repeat (2) @(negedge clk);
    host_rd('h160, v); check("R10 fen follows", v, 1);
    // R7 no tag yet
    e0 = err_cnt;
    host_wr('h154, 'h33); host_wr('h155, 'h44); @(negedge clk);
    check("R7 err no tag", err_cnt - e0, 2);
    expect_empty("R7 no tag empty");
    // R4 tag, R5 word sweep
    host_wr('h151, 'h40);
    expect_entry("R4 tag", 1, 'h0040);
    e0 = err_cnt;
    for (int k = 0; k < 64; k++) begin
      int w = ((k * 'h0405) ^ 'hA55A) & 'hffff;
      host_wr('h154, w & 'hff); host_wr('h155, w >> 8);
      expect_entry("R5 word", 2, w);
    end
    check("R5 no err", err_cnt - e0, 0);
    // R6 orphan high
    e0 = err_cnt;
    host_wr('h155, 'h99); @(negedge clk);
    check("R6 orphan err", err_cnt - e0, 1);
    expect_empty("R6 nothing pushed");
    // R5 low replaced
    host_wr('h154, 'h01); host_wr('h154, 'h02); host_wr('h155, 'h03);
    expect_entry("R5 low replaced", 2, 'h0302);
    // R8 byte closes burst, held low discarded
    host_wr('h154, 'h55);
    host_wr('h151, 'h12);
    expect_entry("R8 closing byte", 0, 'h12);
    e0 = err_cnt;
    host_wr('h155, 'h66); @(negedge clk);
    check("R8 closed err", err_cnt - e0, 1);
    expect_empty("R8 closed empty");
    // R9 full buffer
    host_wr('h151, 'h40);
    for (int k = 0; k < 3; k++) begin host_wr('h154, k); host_wr('h155, 'hA0 + k); end
    host_rd('h153, v); check("R9 ostat full", v, 0);
    host_wr('h154, 'h77); host_wr('h155, 'h88);
    host_wr('h151, 'h05);
    expect_entry("R9 keep tag", 1, 'h0040);
    for (int k = 0; k < 3; k++) expect_entry("R9 keep word", 2, ((('hA0 + k) << 8) | k));
    expect_empty("R9 dropped");
    host_rd('h153, v); check("R9 ostat free", v, 1);
    // R8 disable closes burst
    host_wr('h154, 'h10);
    fifo_en = 0; repeat (2) @(negedge clk);
    e0 = err_cnt;
    host_wr('h155, 'h20); @(negedge clk);
    check("R8 disable err", err_cnt - e0, 1);
    host_wr('h151, 'h40);
    expect_entry("R3 tag value as byte", 0, 'h40);
    host_rd('h160, v); check("R1 fen off", v, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule